// File: doc/BRIEF.md
# Range Cache Maintenance Engine

This block walks a physical address range and asks the cache to write back and then invalidate every 128-byte line that the range touches. Software sets a 64-bit start address and a 64-bit length through 32-bit registers. The length holds the offset of the last byte, so it is the size minus one. Software then writes the control register with the go bit, range mode and the clean-and-invalidate type. The go bit stays readable as 1 while the walk runs, and software polls it until it drops to 0.

For each line the engine puts the line address on a valid/ready request port. A companion input, `line_hit`, reports whether this instance owns the line and currently holds it. When `line_hit` is low the engine skips the line in one cycle with no request, and the operation still counts as successful.

A command that does not select range mode or that names an unsupported type issues nothing and sets a sticky reject flag. A range whose end passes the top of the 64-bit space stops at the highest line.

Top module: `range_maint_engine`

## Requirements
- R1: After reset every register reads 0 and `req_valid` is low.
- R2: The register offsets are: start low word 0x5008, start high word 0x500C, length low word 0x5010, length high word 0x5014, control 0x5004. The control bits are: bit 0 go/busy, bit 1 range mode, bits 3:2 type, bit 4 reject flag (read only). The other bits read 0.
- R3: Writing control with bit 0 = 1, bit 1 = 1 and type = 1 while idle makes bit 0 read 1 from the next cycle on.
- R4: Requests carry the 128-byte-aligned line addresses in ascending order. They run from the line that holds the start byte to the line that holds byte start+length, and each owned line is issued exactly once.
- R5: While `req_valid` is high and `req_ready` is low, `req_addr` holds and `req_valid` stays high. `req_op` reads 1 (clean-and-invalidate) on every request.
- R6: A line with `line_hit` low raises no request and costs one cycle. A walk in which no line is owned still completes.
- R7: Bit 0 of control reads 0 in the cycle after the last line is accepted or skipped.
- R8: While busy, writes to the start, length and control registers have no effect, and software cannot clear bit 0.
- R9: A go write with range mode clear or with type other than 1 issues no request and leaves bit 0 at 0. It sets the reject flag, which stays set until a valid command starts.
- R10: If start+length passes 2^64 - 1, the walk ends after line 0xFFFF_FFFF_FFFF_FF80.
- R11: A control write with bit 0 = 0 while idle stores the range and type fields, starts nothing and leaves the reject flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | REG_AW | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| line_hit | input | 1 | Current line is owned and present |
| req_valid | output | 1 | Maintenance request valid |
| req_ready | input | 1 | Maintenance request accepted |
| req_addr | output | 64 | Aligned line address of the current line |
| req_op | output | 2 | Operation code, 1 = clean-and-invalidate |

## Verification
The bench builds the engine with its default 128-byte lines, 16-bit register offsets and the default offset map. With those values the 64-bit top-of-space wrap is reached in a two-line walk. The 8-entry ownership mask, indexed by address bits 9:7, gives each vector a repeatable pattern of owned and skipped lines, and the 8-cycle ready pattern gives stalls at different points in the walk.

// File: rtl/range_maint_engine.sv
module range_maint_engine #(
  parameter int REG_AW = 16,
  parameter int LINE_BYTES = 128,
  parameter logic [REG_AW-1:0] OFS_CTRL = 16'h5004,
  parameter logic [REG_AW-1:0] OFS_ST_LO = 16'h5008,
  parameter logic [REG_AW-1:0] OFS_ST_HI = 16'h500C,
  parameter logic [REG_AW-1:0] OFS_LN_LO = 16'h5010,
  parameter logic [REG_AW-1:0] OFS_LN_HI = 16'h5014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              line_hit,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [1:0]        req_op
);
  localparam int LSB = $clog2(LINE_BYTES);
  localparam logic [1:0] OP_CINV = 2'd1;
  localparam logic [63:0] TOP_LINE = {{(64-LSB){1'b1}}, {LSB{1'b0}}};

  logic [63:0] start_q, len_q, cur_q, last_q;
  logic        busy_q, range_q, rej_q;
  logic [1:0]  type_q;

  logic [64:0] end_sum;
  logic [63:0] first_line, last_line;
  logic        cmd_ok, step, idle_we;

  assign end_sum    = {1'b0, start_q} + {1'b0, len_q};
  assign first_line = {start_q[63:LSB], {LSB{1'b0}}};
  assign last_line  = end_sum[64] ? TOP_LINE : {end_sum[63:LSB], {LSB{1'b0}}};
  assign cmd_ok     = reg_wdata[1] && (reg_wdata[3:2] == OP_CINV);
  assign idle_we    = reg_we && !busy_q;

  assign req_valid = busy_q && line_hit;
  assign req_addr  = cur_q;
  assign req_op    = OP_CINV;
  assign step      = busy_q && (!line_hit || req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
      range_q <= 1'b0;
      rej_q   <= 1'b0;
      type_q  <= '0;
    end else begin
      if (idle_we) begin
        case (reg_waddr)
          OFS_ST_LO: start_q[31:0]  <= reg_wdata;
          OFS_ST_HI: start_q[63:32] <= reg_wdata;
          OFS_LN_LO: len_q[31:0]    <= reg_wdata;
          OFS_LN_HI: len_q[63:32]   <= reg_wdata;
          OFS_CTRL: begin
            range_q <= reg_wdata[1];
            type_q  <= reg_wdata[3:2];
            if (reg_wdata[0]) begin
              if (cmd_ok) begin
                busy_q <= 1'b1;
                rej_q  <= 1'b0;
                cur_q  <= first_line;
                last_q <= last_line;
              end else begin
                rej_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      if (step) begin
        if (cur_q == last_q) busy_q <= 1'b0;
        else cur_q <= cur_q + 64'(LINE_BYTES);
      end
    end
  end

  always_comb begin
    case (reg_raddr)
      OFS_CTRL:  reg_rdata = {27'd0, rej_q, type_q, range_q, busy_q};
      OFS_ST_LO: reg_rdata = start_q[31:0];
      OFS_ST_HI: reg_rdata = start_q[63:32];
      OFS_LN_LO: reg_rdata = len_q[31:0];
      OFS_LN_HI: reg_rdata = len_q[63:32];
      default:   reg_rdata = '0;
    endcase
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> busy_q && $stable(req_addr));

  // R4
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LSB-1:0] == '0);

  // R7
  stop_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cur_q == last_q));

  // R10
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> last_q >= cur_q);

  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && busy_q && reg_waddr == OFS_ST_LO |=> $stable(start_q[31:0]));

  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !busy_q && reg_waddr == OFS_CTRL && reg_wdata[0] && !cmd_ok
    |=> !busy_q && rej_q);
endmodule

// File: tb/range_maint_engine_tb.sv
module range_maint_engine_tb;
  localparam logic [15:0] A_CTRL = 16'h5004, A_SLO = 16'h5008, A_SHI = 16'h500C,
                          A_LLO = 16'h5010, A_LHI = 16'h5014;
  localparam int NV = 7;
  localparam logic [63:0] V_START [NV] = '{64'h1000, 64'h1010, 64'h2040, 64'h3000,
    64'h4000, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FF80};
  localparam logic [63:0] V_LEN [NV] = '{64'h7F, 64'h7F, 64'h3FF, 64'h0,
    64'h37F, 64'h1000, 64'h7F};
  localparam logic [7:0] V_HIT [NV] = '{8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'h00, 8'hFF, 8'hFF};
  localparam logic [7:0] V_RDY [NV] = '{8'hFF, 8'h55, 8'hFF, 8'h80, 8'hFF, 8'h33, 8'hFF};
  localparam int V_NREQ [NV] = '{1, 2, 5, 1, 0, 2, 1};

  logic clk = 0, rst_n = 0, reg_we = 0, req_ready = 0;
  logic [15:0] reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] hit_mask = 8'hFF;
  logic line_hit, req_valid;
  logic [63:0] req_addr;
  logic [1:0] req_op;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign line_hit = hit_mask[req_addr[9:7]];

  range_maint_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .line_hit(line_hit), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_vec(input int i);
    logic [31:0] r;
    logic [64:0] sum;
    logic [63:0] p, last, stall_addr;
    longint unsigned rem;
    int n;
    bit last_flag, stall;
    req_ready = 0;
    hit_mask = V_HIT[i];
    wr(A_SLO, V_START[i][31:0]); wr(A_SHI, V_START[i][63:32]);
    wr(A_LLO, V_LEN[i][31:0]);   wr(A_LHI, V_LEN[i][63:32]);
    sum = {1'b0, V_START[i]} + {1'b0, V_LEN[i]};
    last = sum[64] ? 64'hFFFF_FFFF_FFFF_FF80 : {sum[63:7], 7'd0};
    p = {V_START[i][63:7], 7'd0};
    rem = ((last - p) >> 7) + 1;
    n = 0; last_flag = 0; stall = 0;
    wr(A_CTRL, 32'h7);
    for (int it = 0; it < 3000; it++) begin
      req_ready = V_RDY[i][it % 8];
      rd(A_CTRL, r);
      if (it == 0) chk(r[0] == 1'b1, "R3 busy after go", 64'(r[0]), 64'd1);
      if (last_flag) chk(r[0] == 1'b0, "R7 busy clears after last line", 64'(r[0]), 64'd0);
      last_flag = 0;
      if (stall) chk(req_valid && req_addr == stall_addr, "R5 request held", req_addr, stall_addr);
      stall = 0;
      if (!r[0]) break;
      if (it == 2999) chk(0, "R7 walk did not finish", 64'(it), 64'd0);
      if (req_valid) begin
        if (req_ready) begin
          while (rem > 0 && !V_HIT[i][p[9:7]]) begin p = p + 128; rem--; end
          chk(req_addr == p, (i == 5) ? "R10 wrap line" : "R4 line address", req_addr, p);
          chk(req_op == 2'd1, "R5 op code", 64'(req_op), 64'd1);
          n++;
          if (p == last) last_flag = 1;
          p = p + 128; rem--;
        end else begin
          stall = 1; stall_addr = req_addr;
        end
      end
      @(negedge clk);
    end
    chk(n == V_NREQ[i], (i == 4) ? "R6 skipped lines" : "R4 request count", 64'(n), 64'(V_NREQ[i]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_CTRL, r); chk(r == 0, "R1 ctrl reset", 64'(r), 0);
    rd(A_SLO, r);  chk(r == 0, "R1 start reset", 64'(r), 0);
    rd(A_LHI, r);  chk(r == 0, "R1 length reset", 64'(r), 0);
    chk(req_valid == 0, "R1 no request", 64'(req_valid), 0);

    wr(A_SLO, 32'h1234_5680); wr(A_SHI, 32'h9ABC_DEF0);
    wr(A_LLO, 32'h0000_0F0F); wr(A_LHI, 32'h0000_0001);
    rd(A_SLO, r); chk(r == 32'h1234_5680, "R2 start low", 64'(r), 64'h1234_5680);
    rd(A_SHI, r); chk(r == 32'h9ABC_DEF0, "R2 start high", 64'(r), 64'h9ABC_DEF0);
    rd(A_LLO, r); chk(r == 32'h0000_0F0F, "R2 length low", 64'(r), 64'hF0F);
    rd(A_LHI, r); chk(r == 32'h1, "R2 length high", 64'(r), 64'h1);

    for (int i = 0; i < NV; i++) run_vec(i);

    hit_mask = 8'hFF; req_ready = 0;
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, r); chk(r == 32'h12, "R9 reject type 0", 64'(r), 64'h12);
    chk(req_valid == 0, "R9 no request on reject", 64'(req_valid), 0);
    wr(A_CTRL, 32'h5);
    rd(A_CTRL, r); chk(r == 32'h14, "R9 reject range clear", 64'(r), 64'h14);
    wr(A_CTRL, 32'h6);
    rd(A_CTRL, r); chk(r == 32'h16, "R11 fields without go", 64'(r), 64'h16);
    chk(req_valid == 0, "R11 no request", 64'(req_valid), 0);

    wr(A_SLO, 32'h8000); wr(A_SHI, 0); wr(A_LLO, 32'hFF); wr(A_LHI, 0);
    wr(A_CTRL, 32'h7);
    rd(A_CTRL, r); chk(r == 32'h7, "R9 reject flag cleared by start", 64'(r), 64'h7);
    wr(A_SLO, 32'hDEAD_0000);
    wr(A_LLO, 32'h5);
    wr(A_CTRL, 32'h0);
    rd(A_SLO, r);  chk(r == 32'h8000, "R8 start locked", 64'(r), 64'h8000);
    rd(A_LLO, r);  chk(r == 32'hFF, "R8 length locked", 64'(r), 64'hFF);
    rd(A_CTRL, r); chk(r == 32'h7, "R8 busy not clearable", 64'(r), 64'h7);
    chk(req_valid && req_addr == 64'h8000, "R8 walk unchanged", req_addr, 64'h8000);
    req_ready = 1; n = 0;
    for (int it = 0; it < 50; it++) begin
      rd(A_CTRL, r);
      if (!r[0]) break;
      if (req_valid) n++;
      @(negedge clk);
    end
    chk(n == 2, "R8 original range walked", 64'(n), 64'd2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule